// File: doc/BRIEF.md
# General-Purpose Event and Hotplug Status Register Set

This block holds the event status and event enable registers that a host polls after a system-event interrupt. It also holds a presence map of processors and a pair of slot-change maps for PCI hotplug. The host reaches all of it over one byte-addressed register port. The event-status and processor areas are byte-wide. Accesses to them use bits 7:0 of the data bus, and reads from them return zero in the upper bits. The hotplug area is word-wide.

Two event inputs report changes from the platform. A processor event adds or removes one processor from the presence map. A slot event reports one slot insertion or removal. Each event latches a status bit and can raise a one-cycle interrupt pulse. A host write to the eject register produces a one-cycle strobe that carries the slot number to eject.

Top module: `evt_hotplug_regs`

## Requirements
- R1: Address 0x00 is event status bits 7:0, 0x01 is status bits 15:8, 0x02 is enable bits 7:0 and 0x03 is enable bits 15:8. A read returns the byte in bus_rdata[7:0] with all upper bits zero. A read of an unmapped address returns zero.
- R2: A write to 0x00 or 0x01 clears each status bit of that byte whose written data bit is 1. Bits written 0 and the other byte keep their values.
- R3: A write to 0x02 or 0x03 replaces the addressed enable byte and leaves the other enable byte unchanged.
- R4: Processor n appears at address 0x20 + n/8, bit n%8. The area covers 32 bytes. Host writes to 0x20–0x3F change nothing.
- R5: At reset the processor map has bits 0 to NUM_CPUS-1 set and all other bits clear. With the default NUM_CPUS of 10, byte 0x20 is 0xFF, byte 0x21 is 0x03 and all others are 0x00.
- R6: A processor event with cpu_evt_add=1 sets that processor's bit, and with cpu_evt_add=0 clears it. Either kind sets status bit 2.
- R7: A slot event first clears both the up map (read at 0x40) and the down map (read at 0x44). It then sets the slot's bit in up for an insertion or in down for a removal, and sets status bit 1.
- R8: sci_pulse is high for exactly the cycle after a processor event when enable bit 2 is set, or after a slot event when enable bit 1 is set. The enable value sampled is the one present at the event. Otherwise sci_pulse stays low.
- R9: A nonzero write to 0x48 gives eject_strobe high for the following cycle. eject_slot then holds the index of the lowest set bit of the written word. A write of zero gives no strobe. A read of 0x48 returns 0.
- R10: After reset, status, enable, up and down are zero and sci_pulse and eject_strobe are low.
- R11: When an event sets a status bit in the same cycle that a host write clears it, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Host write enable for this cycle |
| bus_addr | input | 8 | Host register address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cpu_evt_valid | input | 1 | Processor event this cycle |
| cpu_evt_add | input | 1 | 1 = processor added, 0 = removed |
| cpu_evt_id | input | 8 | Processor number |
| slot_evt_valid | input | 1 | Slot event this cycle |
| slot_evt_insert | input | 1 | 1 = insertion, 0 = removal |
| slot_evt_id | input | 5 | Slot number |
| sci_pulse | output | 1 | One-cycle event interrupt |
| eject_strobe | output | 1 | One-cycle eject request |
| eject_slot | output | 5 | Slot to eject, valid with eject_strobe |

## Verification
The bench targets the byte-lane corners of the status register. A design that cleared by byte value instead of by set bits, or that touched the other lane, would leave wrong bits after a lane clear. It also targets a clear that meets an event in the same cycle. A design that let the clear win would drop the event. Eject writes with only bit 31 set, with several bits set, and with zero catch an encoder that picks the highest bit or that strobes on zero. Back-to-back slot insertions and removals show whether the maps are cleared before each set, and host writes into the processor area catch a map that the host can write.

// File: rtl/evt_pkg.sv
// Package: address map and status bit positions shared by the register set.
// Assumes an 8-bit byte address space with the processor area 32 bytes long.
package evt_pkg;
    localparam logic [7:0] GPE_BASE  = 8'h00;
    localparam logic [7:0] CPU_BASE  = 8'h20;
    localparam logic [7:0] HP_UP     = 8'h40;
    localparam logic [7:0] HP_DOWN   = 8'h44;
    localparam logic [7:0] HP_EJECT  = 8'h48;
    localparam int         STS_SLOT_BIT = 1;
    localparam int         STS_CPU_BIT  = 2;

    // Byte lanes of the event register window, selected by address bits 1:0.
    typedef enum logic [1:0] {
        LANE_STS_LO = 2'd0,
        LANE_STS_HI = 2'd1,
        LANE_EN_LO  = 2'd2,
        LANE_EN_HI  = 2'd3
    } gpe_lane_e;
endpackage

// File: rtl/gpe_regs.sv
// Event status and enable registers, written one byte lane at a time.
// Status clears where written bits are 1; set requests win over clears.
// Assumes at most one host write per cycle.
module gpe_regs (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_lane,
    input  logic [7:0]  wr_byte,
    input  logic [15:0] set_bits,
    output logic [15:0] sts,
    output logic [15:0] en
);
    import evt_pkg::*;

    logic [15:0] clr_mask;
    logic [15:0] en_next;

    // Build the clear mask for the addressed status lane.
    always_comb begin
        clr_mask = '0;
        if (wr_en && wr_lane == LANE_STS_LO) clr_mask[7:0]  = wr_byte;
        if (wr_en && wr_lane == LANE_STS_HI) clr_mask[15:8] = wr_byte;
    end

    // Replace only the addressed enable lane.
    always_comb begin
        en_next = en;
        if (wr_en && wr_lane == LANE_EN_LO) en_next[7:0]  = wr_byte;
        if (wr_en && wr_lane == LANE_EN_HI) en_next[15:8] = wr_byte;
    end

    // Register both words; new events override same-cycle clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts <= '0;
            en  <= '0;
        end else begin
            sts <= (sts & ~clr_mask) | set_bits;
            en  <= en_next;
        end
    end
endmodule

// File: rtl/cpu_presence.sv
// Processor presence bitmap, one bit per processor, changed only by events.
// Reset value marks processors 0..NUM_CPUS-1 present.
module cpu_presence #(
    parameter int NUM_CPUS  = 10,
    parameter int MAP_BYTES = 32,
    localparam int MAP_BITS = MAP_BYTES * 8,
    localparam int ID_W     = $clog2(MAP_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                evt_valid,
    input  logic                evt_add,
    input  logic [ID_W-1:0]     evt_id,
    output logic [MAP_BITS-1:0] cpu_map
);
    // Compute the reset pattern: whole groups of 8 give 0xFF, the rest a low mask.
    function automatic logic [MAP_BITS-1:0] reset_map();
        logic [MAP_BITS-1:0] v;
        for (int b = 0; b < MAP_BITS; b++) v[b] = (b < NUM_CPUS);
        return v;
    endfunction

    localparam logic [MAP_BITS-1:0] RESET_MAP = reset_map();

    // Set or clear the addressed processor bit on an event.
    always_ff @(posedge clk) begin
        if (!rst_n)         cpu_map <= RESET_MAP;
        else if (evt_valid) cpu_map[evt_id] <= evt_add;
    end
endmodule

// File: rtl/slot_status.sv
// Slot up/down bitmaps; each slot event wipes both and records one bit.
module slot_status #(
    parameter int NUM_SLOTS = 32,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt_valid,
    input  logic                 evt_insert,
    input  logic [SLOT_W-1:0]    evt_id,
    output logic [NUM_SLOTS-1:0] slot_up,
    output logic [NUM_SLOTS-1:0] slot_down
);
    logic [NUM_SLOTS-1:0] one_hot;

    // Decode the slot number to a single bit.
    always_comb begin
        one_hot = '0;
        one_hot[evt_id] = 1'b1;
    end

    // Clear both maps, then record the latest event in one of them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_up   <= '0;
            slot_down <= '0;
        end else if (evt_valid) begin
            slot_up   <= evt_insert ? one_hot : '0;
            slot_down <= evt_insert ? '0 : one_hot;
        end
    end
endmodule

// File: rtl/eject_encoder.sv
// Turns an eject write into a one-cycle strobe with the lowest set bit's index.
// A zero word produces no strobe.
module eject_encoder #(
    parameter int NUM_SLOTS = 32,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [NUM_SLOTS-1:0] wr_data,
    output logic                 strobe,
    output logic [SLOT_W-1:0]    slot
);
    logic [SLOT_W-1:0] low_idx;

    // Priority encode from the top so the lowest set bit is taken last.
    always_comb begin
        low_idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (wr_data[i]) low_idx = SLOT_W'(i);
        end
    end

    // Register the strobe and slot number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe <= 1'b0;
            slot   <= '0;
        end else begin
            strobe <= wr_en && (wr_data != '0);
            if (wr_en && (wr_data != '0)) slot <= low_idx;
        end
    end
endmodule

// File: rtl/evt_hotplug_regs.sv
// Top of the event/hotplug register set: address decode, read mux and
// interrupt pulse. Assumes one host access per cycle and reads that are
// combinational on bus_addr.
module evt_hotplug_regs #(
    parameter int NUM_CPUS  = 10,
    parameter int MAP_BYTES = 32,
    parameter int NUM_SLOTS = 32,
    localparam int CPU_ID_W = $clog2(MAP_BYTES * 8),
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [7:0]           bus_addr,
    input  logic [NUM_SLOTS-1:0] bus_wdata,
    output logic [NUM_SLOTS-1:0] bus_rdata,
    input  logic                 cpu_evt_valid,
    input  logic                 cpu_evt_add,
    input  logic [CPU_ID_W-1:0]  cpu_evt_id,
    input  logic                 slot_evt_valid,
    input  logic                 slot_evt_insert,
    input  logic [SLOT_W-1:0]    slot_evt_id,
    output logic                 sci_pulse,
    output logic                 eject_strobe,
    output logic [SLOT_W-1:0]    eject_slot
);
    import evt_pkg::*;

    localparam int         MAP_BITS  = MAP_BYTES * 8;
    localparam int         MAP_IDX_W = $clog2(MAP_BYTES);
    localparam logic [7:0] CPU_END   = 8'(CPU_BASE + MAP_BYTES);

    logic                  hit_gpe;
    logic                  hit_cpu;
    logic [15:0]           gpe_sts;
    logic [15:0]           gpe_en;
    logic [15:0]           sts_set;
    logic [MAP_BITS-1:0]   cpu_map;
    logic [NUM_SLOTS-1:0]  slot_up;
    logic [NUM_SLOTS-1:0]  slot_down;
    logic [MAP_IDX_W-1:0]  cpu_byte_idx;

    // Region decode for the byte-wide areas.
    always_comb begin
        hit_gpe      = (bus_addr[7:2] == GPE_BASE[7:2]);
        hit_cpu      = (bus_addr >= CPU_BASE) && (bus_addr < CPU_END);
        cpu_byte_idx = MAP_IDX_W'(bus_addr - CPU_BASE);
    end

    // Status bits raised by incoming events.
    always_comb begin
        sts_set = '0;
        sts_set[STS_CPU_BIT]  = cpu_evt_valid;
        sts_set[STS_SLOT_BIT] = slot_evt_valid;
    end

    gpe_regs u_gpe (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr && hit_gpe),
        .wr_lane  (bus_addr[1:0]),
        .wr_byte  (bus_wdata[7:0]),
        .set_bits (sts_set),
        .sts      (gpe_sts),
        .en       (gpe_en)
    );

    cpu_presence #(.NUM_CPUS(NUM_CPUS), .MAP_BYTES(MAP_BYTES)) u_cpu (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_valid (cpu_evt_valid),
        .evt_add   (cpu_evt_add),
        .evt_id    (cpu_evt_id),
        .cpu_map   (cpu_map)
    );

    slot_status #(.NUM_SLOTS(NUM_SLOTS)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_valid  (slot_evt_valid),
        .evt_insert (slot_evt_insert),
        .evt_id     (slot_evt_id),
        .slot_up    (slot_up),
        .slot_down  (slot_down)
    );

    eject_encoder #(.NUM_SLOTS(NUM_SLOTS)) u_eject (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr && bus_addr == HP_EJECT),
        .wr_data (bus_wdata),
        .strobe  (eject_strobe),
        .slot    (eject_slot)
    );

    // Read mux: byte areas zero-extended, hotplug words full width, rest zero.
    always_comb begin
        bus_rdata = '0;
        if (hit_gpe) begin
            case (bus_addr[1:0])
                LANE_STS_LO: bus_rdata[7:0] = gpe_sts[7:0];
                LANE_STS_HI: bus_rdata[7:0] = gpe_sts[15:8];
                LANE_EN_LO:  bus_rdata[7:0] = gpe_en[7:0];
                default:     bus_rdata[7:0] = gpe_en[15:8];
            endcase
        end else if (hit_cpu) begin
            bus_rdata[7:0] = cpu_map[{cpu_byte_idx, 3'b000} +: 8];
        end else if (bus_addr == HP_UP) begin
            bus_rdata = slot_up;
        end else if (bus_addr == HP_DOWN) begin
            bus_rdata = slot_down;
        end
    end

    // One-cycle interrupt qualified by the enable in force at the event.
    always_ff @(posedge clk) begin
        if (!rst_n) sci_pulse <= 1'b0;
        else        sci_pulse <= (cpu_evt_valid  && gpe_en[STS_CPU_BIT]) ||
                                 (slot_evt_valid && gpe_en[STS_SLOT_BIT]);
    end
endmodule

// File: rtl/evt_hotplug_regs_chk.sv
// Property checker for evt_hotplug_regs, attached with bind below.
module evt_hotplug_regs_chk #(
    parameter int MAP_BITS  = 256,
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic [7:0]           bus_addr,
    input logic [NUM_SLOTS-1:0] bus_wdata,
    input logic                 cpu_evt_valid,
    input logic                 slot_evt_valid,
    input logic                 sci_pulse,
    input logic                 eject_strobe,
    input logic [SLOT_W-1:0]    eject_slot,
    input logic [15:0]          gpe_sts,
    input logic [MAP_BITS-1:0]  cpu_map,
    input logic [NUM_SLOTS-1:0] slot_up,
    input logic [NUM_SLOTS-1:0] slot_down
);
    // R8: a pulse only follows an event.
    p_sci_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sci_pulse |-> $past(cpu_evt_valid || slot_evt_valid));

    // R9: a strobe only follows a nonzero eject write.
    p_eject_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eject_strobe |-> $past(bus_wr && bus_addr == 8'h48 && bus_wdata != '0));

    // R9: the reported slot is a set bit with no set bit below it.
    p_eject_lowest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eject_strobe |-> ((($past(bus_wdata) >> eject_slot) & 1) == 1) &&
                         (($past(bus_wdata) & ((NUM_SLOTS'(1) << eject_slot) - 1)) == '0));

    // R7: at most one bit across both slot maps.
    p_slot_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({slot_up, slot_down}));

    // R4: host writes into the processor area leave the map alone.
    p_cpu_readonly_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr >= 8'h20 && bus_addr < 8'h40 && !cpu_evt_valid)
        |=> $stable(cpu_map));

    // R6/R11: a processor event always leaves status bit 2 set.
    p_cpu_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_evt_valid |=> gpe_sts[2]);
endmodule

bind evt_hotplug_regs evt_hotplug_regs_chk #(
    .MAP_BITS(MAP_BYTES * 8), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_wr         (bus_wr),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .cpu_evt_valid  (cpu_evt_valid),
    .slot_evt_valid (slot_evt_valid),
    .sci_pulse      (sci_pulse),
    .eject_strobe   (eject_strobe),
    .eject_slot     (eject_slot),
    .gpe_sts        (gpe_sts),
    .cpu_map        (cpu_map),
    .slot_up        (slot_up),
    .slot_down      (slot_down)
);

// File: tb/evt_hotplug_regs_bench.sv
`timescale 1ns/1ps
module evt_hotplug_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cpu_evt_valid = 1'b0, cpu_evt_add = 1'b0;
    logic [7:0]  cpu_evt_id = '0;
    logic        slot_evt_valid = 1'b0, slot_evt_insert = 1'b0;
    logic [4:0]  slot_evt_id = '0;
    logic        sci_pulse, eject_strobe;
    logic [4:0]  eject_slot;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // Reference model state.
    logic [15:0]  m_sts, m_en;
    logic [255:0] m_cpu;
    logic [31:0]  m_up, m_down;

    always #5 clk = ~clk;

    evt_hotplug_regs u_evt_hotplug_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_evt_valid(cpu_evt_valid), .cpu_evt_add(cpu_evt_add), .cpu_evt_id(cpu_evt_id),
        .slot_evt_valid(slot_evt_valid), .slot_evt_insert(slot_evt_insert),
        .slot_evt_id(slot_evt_id), .sci_pulse(sci_pulse),
        .eject_strobe(eject_strobe), .eject_slot(eject_slot)
    );

    function automatic logic [31:0] model_read(input logic [7:0] a);
        if (a == 8'h00) return {24'h0, m_sts[7:0]};
        if (a == 8'h01) return {24'h0, m_sts[15:8]};
        if (a == 8'h02) return {24'h0, m_en[7:0]};
        if (a == 8'h03) return {24'h0, m_en[15:8]};
        if (a >= 8'h20 && a < 8'h40) return {24'h0, m_cpu[(a - 8'h20) * 8 +: 8]};
        if (a == 8'h40) return m_up;
        if (a == 8'h44) return m_down;
        return 32'h0;
    endfunction

    function automatic int lowest_bit(input logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return i;
        return 0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_check(input logic [7:0] a, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, model_read(a));
    endtask

    // One cycle of stimulus, then compare pulse outputs and update the model.
    task automatic op(input logic wr, input logic [7:0] a, input logic [31:0] d,
                      input logic cv, input logic cadd, input logic [7:0] cid,
                      input logic sv, input logic sins, input logic [4:0] sid);
        logic e_sci, e_ej;
        logic [15:0] clr;
        int e_slot;
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        cpu_evt_valid = cv; cpu_evt_add = cadd; cpu_evt_id = cid;
        slot_evt_valid = sv; slot_evt_insert = sins; slot_evt_id = sid;
        e_sci  = (cv && m_en[2]) || (sv && m_en[1]);
        e_ej   = wr && a == 8'h48 && d != 0;
        e_slot = lowest_bit(d);
        clr = '0;
        if (wr && a == 8'h00) clr[7:0]  = d[7:0];
        if (wr && a == 8'h01) clr[15:8] = d[7:0];
        m_sts = m_sts & ~clr;
        if (wr && a == 8'h02) m_en[7:0]  = d[7:0];
        if (wr && a == 8'h03) m_en[15:8] = d[7:0];
        if (cv) begin m_cpu[cid] = cadd; m_sts[2] = 1'b1; end
        if (sv) begin
            m_up = '0; m_down = '0;
            if (sins) m_up[sid] = 1'b1; else m_down[sid] = 1'b1;
            m_sts[1] = 1'b1;
        end
        @(negedge clk);
        bus_wr = 1'b0; cpu_evt_valid = 1'b0; slot_evt_valid = 1'b0;
        check("R8 sci_pulse", 32'(sci_pulse), 32'(e_sci));
        check("R9 eject_strobe", 32'(eject_strobe), 32'(e_ej));
        if (e_ej) check("R9 eject_slot", 32'(eject_slot), 32'(e_slot));
    endtask

    task automatic host_wr(input logic [7:0] a, input logic [31:0] d);
        op(1'b1, a, d, 1'b0, 1'b0, 8'h0, 1'b0, 1'b0, 5'h0);
    endtask

    initial begin
        m_sts = '0; m_en = '0; m_up = '0; m_down = '0;
        for (int b = 0; b < 256; b++) m_cpu[b] = (b < 10);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state and R5 processor map reset value.
        check("R10 sci_pulse at reset", 32'(sci_pulse), 32'h0);
        check("R10 eject_strobe at reset", 32'(eject_strobe), 32'h0);
        for (int a = 0; a < 4; a++) read_check(8'(a), "R10 event regs at reset");
        read_check(8'h40, "R10 up at reset");
        read_check(8'h44, "R10 down at reset");
        read_check(8'h20, "R5 cpu byte 0");
        read_check(8'h21, "R5 cpu byte 1");
        read_check(8'h22, "R5 cpu byte 2");
        read_check(8'h3F, "R5 cpu byte 31");
        // R3 enable lanes.
        host_wr(8'h02, 32'hFFFF_FF06);
        host_wr(8'h03, 32'h0000_00A5);
        read_check(8'h02, "R3 enable low lane");
        read_check(8'h03, "R3 enable high lane");
        read_check(8'h00, "R1 status low unaffected");
        // R6/R8 processor add and remove with enable.
        op(1'b0, 8'h00, 0, 1'b1, 1'b1, 8'd12, 1'b0, 1'b0, 5'd0);
        read_check(8'h21, "R6 cpu add bit 12");
        op(1'b0, 8'h00, 0, 1'b1, 1'b0, 8'd3, 1'b0, 1'b0, 5'd0);
        read_check(8'h20, "R6 cpu remove bit 3");
        read_check(8'h00, "R6 status bit 2");
        // R7 slot events.
        op(1'b0, 8'h00, 0, 1'b0, 1'b0, 8'd0, 1'b1, 1'b1, 5'd3);
        op(1'b0, 8'h00, 0, 1'b0, 1'b0, 8'd0, 1'b1, 1'b0, 5'd31);
        read_check(8'h40, "R7 up cleared by removal");
        read_check(8'h44, "R7 down slot 31");
        // R2 lane clear: clear bit 1 only, keep bit 2.
        host_wr(8'h00, 32'h0000_0002);
        read_check(8'h00, "R2 clear one status bit");
        host_wr(8'h01, 32'h0000_00FF);
        read_check(8'h00, "R2 other lane kept");
        // R11 clear in same cycle as event.
        op(1'b1, 8'h00, 32'h04, 1'b1, 1'b1, 8'd40, 1'b0, 1'b0, 5'd0);
        read_check(8'h00, "R11 set wins over clear");
        // R4 host write to processor area ignored.
        host_wr(8'h20, 32'h0000_0000);
        host_wr(8'h25, 32'h0000_00FF);
        read_check(8'h20, "R4 write ignored byte 0");
        read_check(8'h25, "R4 write ignored byte 5");
        // R8 disabled enable: no pulse.
        host_wr(8'h02, 32'h0);
        op(1'b0, 8'h00, 0, 1'b1, 1'b1, 8'd1, 1'b1, 1'b1, 5'd1);
        // R9 eject corners.
        host_wr(8'h48, 32'h0);
        host_wr(8'h48, 32'h8000_0000);
        host_wr(8'h48, 32'h0000_0006);
        read_check(8'h48, "R9 eject reads zero");
        read_check(8'h7E, "R1 unmapped reads zero");
        // Random traffic.
        void'($urandom(32'd2024));
        for (int n = 0; n < 400; n++) begin
            logic [7:0] addr_pick;
            int r;
            r = $urandom_range(0, 5);
            case (r)
                0: addr_pick = 8'($urandom_range(0, 3));
                1: addr_pick = 8'h20 + 8'($urandom_range(0, 31));
                2: addr_pick = 8'h48;
                3: addr_pick = 8'h40;
                default: addr_pick = 8'($urandom_range(0, 255));
            endcase
            op(1'($urandom_range(0, 1)), addr_pick,
               ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom(),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 5'($urandom_range(0, 31)));
            read_check(8'($urandom_range(0, 3)), "R2 R3 random event regs");
            read_check(8'h20 + 8'($urandom_range(0, 31)), "R4 R6 random cpu map");
            read_check(($urandom_range(0, 1) == 1) ? 8'h40 : 8'h44, "R7 random slot maps");
        end
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule